// File: doc/BRIEF.md
# Key-Serviced Machine-Cycle Watchdog

This block is a free-running watchdog that software cannot switch off. It counts machine cycles. Each cycle arrives as a one-clock strobe on `mcyc_i`. If the count climbs to its all-ones value, the block raises a chip reset request. The count keeps running while the processor idles. It freezes, without losing its value, while the chip is powered down.

Software restarts the count through a write-only byte port. A restart needs a two-byte key: first 1EH, then E1H, written one after the other. Any other pattern leaves the count alone. The count itself can never be read back.

Once the request is raised, it is held for a fixed number of machine cycles. When that hold ends, the block clears its own counter and key state and starts counting again from zero.

Top module: `cyc_watchdog`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, `rst_req_o` is 0, the count is 0 and no key is pending.
- R2: The 14-bit count advances by exactly one on each clock where `mcyc_i` is 1. It does not change on clocks without a strobe.
- R3: `rst_req_o` rises on the clock edge that follows the count reaching 3FFFH. The count then holds at 3FFFH and does not wrap.
- R4: Once raised, `rst_req_o` stays high until a second strobe has arrived (REQ_MC = 2). It drops on the edge of that second strobe. That same edge clears the count and the key state.
- R5: A write of 1EH followed directly by a write of E1H clears the count on the edge of the E1H write. Such a pair written while `rst_req_o` is high does not shorten the request.
- R6: After 1EH, any write other than E1H cancels the pending key, including a repeated 1EH. A later E1H then leaves the count alone.
- R7: A write of E1H with no pending 1EH has no effect on the count.
- R8: `idle_i` has no effect: counting goes on while it is high.
- R9: While `pdown_i` is high, strobes are ignored and the count keeps its value. Counting resumes from that value when `pdown_i` falls.
- R10: When a key clear and a strobe land on the same edge, the clear wins and the count becomes 0. A clear on the edge where the count becomes 3FFFH therefore prevents the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mcyc_i | input | 1 | Machine-cycle strobe, one clock wide |
| idle_i | input | 1 | Idle status (does not stop counting) |
| pdown_i | input | 1 | Power-down status (freezes the count) |
| wr_en_i | input | 1 | Write strobe for the service register |
| wr_data_i | input | 8 | Byte written to the service register |
| rst_req_o | output | 1 | Chip reset request |

## Verification
Two events can land on the same edge: the final write of the key pair and the strobe that would carry the count to 3FFFH. The bench follows its own model of the count. It places 1EH where the count is 3FFDH and E1H exactly where it is 3FFEH. A correct block must then show no request, and a fresh full period must pass before the next one. A second case writes the key pair while the request is already high. The request must still last its full hold and end exactly on the second strobe.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'h1E;
  localparam logic [7:0] KEY_SECOND = 8'hE1;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_st_e;
endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       flush_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic       clr_o
);
  key_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (flush_i) st_d = KEY_IDLE;
    else if (wr_en_i) begin
      // any write while armed disarms; only an unarmed 1EH arms
      if (st_q == KEY_ARMED) st_d = KEY_IDLE;
      else if (wr_data_i == KEY_FIRST) st_d = KEY_ARMED;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= KEY_IDLE;
    else         st_q <= st_d;
  end

  assign clr_o = wr_en_i && (st_q == KEY_ARMED) && (wr_data_i == KEY_SECOND);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i)                      cnt_q <= '0;
    else if (step_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/wdt_req_hold.sv
module wdt_req_hold #(
  parameter int REQ_MC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic full_i,
  input  logic mcyc_i,
  output logic req_o,
  output logic release_o
);
  localparam int HC_W = (REQ_MC > 1) ? $clog2(REQ_MC) : 1;
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(REQ_MC - 1);

  logic            req_q;
  logic [HC_W-1:0] hcnt_q;

  assign release_o = req_q && mcyc_i && (hcnt_q == HC_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      hcnt_q <= '0;
    end else begin
      if (release_o)   req_q <= 1'b0;
      else if (full_i) req_q <= 1'b1;
      if (!req_q || release_o) hcnt_q <= '0;
      else if (mcyc_i)         hcnt_q <= hcnt_q + 1'b1;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/cyc_watchdog.sv
module cyc_watchdog #(
  parameter int CNT_W  = 14,
  parameter int REQ_MC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mcyc_i,
  input  logic       idle_i,
  input  logic       pdown_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic       rst_req_o
);
  logic             key_clr;
  logic             self_clr;
  logic             cnt_clr;
  logic             cnt_full;
  logic [CNT_W-1:0] cnt_q;

  // idle_i is deliberately not used to gate counting
  assign cnt_clr = key_clr | self_clr;

  wdt_key_seq u_key (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (self_clr),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .clr_o     (key_clr)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (mcyc_i & ~pdown_i),
    .clr_i  (cnt_clr),
    .cnt_o  (cnt_q),
    .full_o (cnt_full)
  );

  wdt_req_hold #(.REQ_MC(REQ_MC)) u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .full_i    (cnt_full),
    .mcyc_i    (mcyc_i),
    .req_o     (rst_req_o),
    .release_o (self_clr)
  );
endmodule

// File: rtl/cyc_watchdog_chk.sv
module cyc_watchdog_chk #(
  parameter int CNT_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mcyc_i,
  input logic             idle_i,
  input logic             pdown_i,
  input logic             rst_req_o,
  input logic [CNT_W-1:0] cnt,
  input logic             clr,
  input logic             key_clr
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  AST_REQ_AFTER_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CNT_MAX && !rst_req_o) |=> rst_req_o); // R3

  AST_NO_STRAY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(cnt) == CNT_MAX); // R3

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mcyc_i && !pdown_i && !clr && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1); // R2

  AST_NO_STROBE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mcyc_i && !clr) |=> $stable(cnt)); // R2

  AST_PDOWN_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdown_i && !clr) |=> $stable(cnt)); // R9

  AST_IDLE_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && mcyc_i && !pdown_i && !clr && cnt != CNT_MAX) |=> cnt != $past(cnt)); // R8

  AST_KEY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_clr |=> cnt == '0); // R5

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |=> rst_req_o); // R4
endmodule

bind cyc_watchdog cyc_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mcyc_i    (mcyc_i),
  .idle_i    (idle_i),
  .pdown_i   (pdown_i),
  .rst_req_o (rst_req_o),
  .cnt       (cnt_q),
  .clr       (cnt_clr),
  .key_clr   (key_clr)
);

// File: tb/cyc_watchdog_tb.sv
module cyc_watchdog_tb;
  localparam int CNT_W  = 14;
  localparam int REQ_MC = 2;
  localparam int MAXV   = (1 << CNT_W) - 1;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mcyc_i = 1'b0;
  logic       idle_i = 1'b0;
  logic       pdown_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       rst_req_o;

  int total = 0;
  int bad = 0;
  int mc_div = 1;
  int mc_ph = 0;
  string tag = "R1";

  always #5 clk_i = ~clk_i;

  cyc_watchdog #(.CNT_W(CNT_W), .REQ_MC(REQ_MC)) u_dut (
    .clk_i, .rst_ni, .mcyc_i, .idle_i, .pdown_i, .wr_en_i, .wr_data_i, .rst_req_o
  );

  // strobe generator, driven away from the active edge
  always @(negedge clk_i) begin
    if (mc_ph + 1 >= mc_div) begin mc_ph = 0; mcyc_i <= 1'b1; end
    else begin mc_ph = mc_ph + 1; mcyc_i <= 1'b0; end
  end

  // reference model built from the requirements; pushes expected request levels
  typedef struct { logic exp; string t; } item_t;
  item_t q[$];
  int m_cnt = 0;
  bit m_armed = 0;
  bit m_req = 0;
  int m_h = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_armed = 0; m_req = 0; m_h = 0;
    end else begin
      bit rel, kc;
      rel = m_req && mcyc_i && (m_h == REQ_MC - 1);                      // R4
      kc  = wr_en_i && m_armed && (wr_data_i == 8'hE1);                  // R5 R7
      if (rel) m_armed = 0;
      else if (wr_en_i) m_armed = !m_armed && (wr_data_i == 8'h1E);      // R6
      if (!m_req || rel) m_h = 0; else if (mcyc_i) m_h = m_h + 1;
      if (rel) m_req = 0; else if (m_cnt == MAXV) m_req = 1;             // R3
      if (rel || kc) m_cnt = 0;                                          // R10
      else if (mcyc_i && !pdown_i && m_cnt != MAXV) m_cnt = m_cnt + 1;   // R2 R8 R9
    end
    q.push_back('{exp: m_req, t: tag});
  end

  // monitor
  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total++;
      if (rst_req_o !== it.exp) begin
        bad++;
        $display("FAIL %s: rst_req_o=%b expected=%b at %0t", it.t, rst_req_o, it.exp, $time);
      end
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i <= 1'b1; wr_data_i <= d;
    @(negedge clk_i);
    wr_en_i <= 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic run_through_req();
    while (!m_req) @(negedge clk_i);
    while (m_req) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tag = "R1";
    cyc(4);
    total++;
    if (rst_req_o !== 1'b0) begin bad++; $display("FAIL R1: rst_req_o=%b expected=0", rst_req_o); end
    rst_ni <= 1'b1;
    cyc(3);

    tag = "R2_R3_R4";
    run_through_req();
    cyc(20);

    tag = "R5";
    cyc(6000); wr(8'h1E); wr(8'hE1);
    run_through_req();

    tag = "R6";
    cyc(1000); wr(8'h1E); wr(8'h55); wr(8'hE1);
    cyc(500);  wr(8'h1E); wr(8'h1E); wr(8'hE1);
    run_through_req();

    tag = "R7";
    cyc(700); wr(8'hE1); wr(8'hE1);
    run_through_req();

    tag = "R8_R2";
    idle_i <= 1'b1;
    mc_div = 3; cyc(2000); mc_div = 1;
    run_through_req();
    idle_i <= 1'b0;

    tag = "R9";
    cyc(500); pdown_i <= 1'b1; cyc(3000); pdown_i <= 1'b0;
    run_through_req();

    tag = "R10";
    while (m_cnt != MAXV - 2) @(negedge clk_i);
    wr_en_i <= 1'b1; wr_data_i <= 8'h1E;
    @(negedge clk_i); wr_data_i <= 8'hE1;
    @(negedge clk_i); wr_en_i <= 1'b0;
    cyc(10);
    total++;
    if (rst_req_o !== 1'b0) begin bad++; $display("FAIL R10: rst_req_o=%b expected=0", rst_req_o); end

    tag = "R5_during_req";
    while (!m_req) @(negedge clk_i);
    wr_en_i <= 1'b1; wr_data_i <= 8'h1E;
    @(negedge clk_i); wr_data_i <= 8'hE1;
    @(negedge clk_i); wr_en_i <= 1'b0;
    cyc(20);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule